// File: doc/BRIEF.md
# Next Program Counter and Branch Resolution Unit

This block computes where a small single-issue core fetches next and how many cycles the current control instruction occupies. For each issued instruction it takes the current program counter, a decoded control-operation code, a signed relative offset, the status register, an externally evaluated compare or bit-test outcome and a flag saying whether the following instruction is two words long. From these it registers the next program counter and the cycle count.

Relative jumps and calls add the offset plus one to the program counter. Returns load the program counter from a value supplied by an external return stack. Conditional branches test one status bit chosen by a 3-bit index against a polarity, or test the signed relation N xor V. Skips step over one or two words depending on the size of the next instruction. Calls raise a one-cycle push request that carries the return address. Returns raise a one-cycle pop request. Interrupt returns also raise a one-cycle request to set the global interrupt enable. All program counter arithmetic wraps modulo 2^PC_W words.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, npc_o is 0, cycles_o is 0, and push_req_o, pop_req_o and set_ie_o are 0.
- R2: Operation codes are 0 sequential, 1 jump, 2 call, 3 return, 4 interrupt return, 5 branch-if-bit-set, 6 branch-if-bit-clear, 7 branch-if-signed-greater-or-equal, 8 branch-if-signed-less-than and 9 skip. A sequential operation, and any code from 10 to 15, yields npc = pc+1 with 1 cycle.
- R3: A jump yields npc = pc + k + 1, where k is the sign-extended offset, with 2 cycles.
- R4: A call yields the same target as a jump, with 3 cycles. It raises push_req_o for one cycle with push_pc_o = pc+1.
- R5: A return or interrupt return yields npc = pop_pc_i with 4 cycles and raises pop_req_o for one cycle. Only the interrupt return also raises set_ie_o. push_req_o and pop_req_o are never high together.
- R6: Status bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Branch-if-bit-set is taken when sreg[flag_sel] is 1, and branch-if-bit-clear is taken when it is 0. A taken branch gives pc+k+1 with 2 cycles. A branch that is not taken gives pc+1 with 1 cycle.
- R7: Signed greater-or-equal is taken when sreg[2] xor sreg[3] is 0. Signed less-than is taken when it is 1. Bit 4 (S) is not consulted.
- R8: A skip with skip_cond_i low gives pc+1 with 1 cycle. With skip_cond_i high it gives pc+2 with 2 cycles when next_two_word_i is 0, and pc+3 with 3 cycles when next_two_word_i is 1.
- R9: Outputs are registered one cycle after a valid_i cycle. In a cycle after valid_i was low, npc_o and cycles_o hold their values and all three request outputs are 0.
- R10: All program counter results wrap modulo 2^PC_W (512 words by default), including a negative offset taken from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is issued this cycle |
| op_i | input | 4 | Control operation code (see R2) |
| pc_i | input | PC_W | Current program counter |
| offset_i | input | OFS_W | Signed relative offset k |
| flag_sel_i | input | 3 | Status bit index for bit branches |
| sreg_i | input | 8 | Status register |
| skip_cond_i | input | 1 | Skip condition outcome from the compare or bit test |
| next_two_word_i | input | 1 | The following instruction is two words long |
| pop_pc_i | input | PC_W | Return address from the stack |
| npc_o | output | PC_W | Next program counter |
| cycles_o | output | 3 | Cycles taken by the instruction |
| push_req_o | output | 1 | Return address push request (one cycle) |
| push_pc_o | output | PC_W | Return address to push |
| pop_req_o | output | 1 | Return address pop request (one cycle) |
| set_ie_o | output | 1 | Set global interrupt enable (one cycle) |

## Verification
The hardest case to reach is the pair of signed branches when the stored S bit disagrees with N xor V. A correct core never produces that status value, so the unit's choice to recompute the relation would go unseen. The vector table drives status words in which S is deliberately inconsistent with N and V. The table also places program counters and offsets at both ends of the address space, so that wrap through zero and through the top word shows up in the registered target.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    OP_SEQ   = 4'd0,
    OP_JMP   = 4'd1,
    OP_CALL  = 4'd2,
    OP_RET   = 4'd3,
    OP_RETI  = 4'd4,
    OP_BSET  = 4'd5,
    OP_BCLR  = 4'd6,
    OP_SGE   = 4'd7,
    OP_SLT   = 4'd8,
    OP_SKIP  = 4'd9
  } br_op_e;

  localparam int SR_N = 2;
  localparam int SR_V = 3;

  localparam int CYC_W = 3;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  br_op_e      op,
  input  logic [2:0]  flag_sel,
  input  logic [7:0]  sreg,
  output logic        br_taken
);

  logic sel_bit;
  logic signed_lt;

  assign sel_bit   = sreg[flag_sel];
  assign signed_lt = sreg[SR_N] ^ sreg[SR_V];

  always_comb begin
    unique case (op)
      OP_BSET: br_taken = sel_bit;
      OP_BCLR: br_taken = ~sel_bit;
      OP_SGE:  br_taken = ~signed_lt;
      OP_SLT:  br_taken = signed_lt;
      default: br_taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int PC_W  = 9,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] offset,
  output logic [PC_W-1:0]  rel_tgt,
  output logic [PC_W-1:0]  step [1:3]
);

  localparam int SUM_W = (PC_W > OFS_W) ? PC_W : OFS_W;

  logic [SUM_W-1:0] ofs_ext;
  logic [SUM_W-1:0] pc_ext;
  logic [SUM_W-1:0] rel_sum;

  assign ofs_ext = SUM_W'($signed(offset));
  assign pc_ext  = SUM_W'(pc);
  assign rel_sum = pc_ext + ofs_ext + SUM_W'(1);
  assign rel_tgt = rel_sum[PC_W-1:0];

  for (genvar d = 1; d <= 3; d++) begin : g_step
    assign step[d] = pc + PC_W'(d);
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int PC_W  = 9,
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [2:0]       flag_sel_i,
  input  logic [7:0]       sreg_i,
  input  logic             skip_cond_i,
  input  logic             next_two_word_i,
  input  logic [PC_W-1:0]  pop_pc_i,
  output logic [PC_W-1:0]  npc_o,
  output logic [2:0]       cycles_o,
  output logic             push_req_o,
  output logic [PC_W-1:0]  push_pc_o,
  output logic             pop_req_o,
  output logic             set_ie_o
);

  br_op_e          op;
  logic            br_taken;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] step [1:3];

  logic [PC_W-1:0]  npc_d;
  logic [CYC_W-1:0] cyc_d;
  logic             push_d, pop_d, ie_d;

  assign op = br_op_e'(op_i);

  npc_cond u_cond (
    .op       (op),
    .flag_sel (flag_sel_i),
    .sreg     (sreg_i),
    .br_taken (br_taken)
  );

  npc_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
    .pc      (pc_i),
    .offset  (offset_i),
    .rel_tgt (rel_tgt),
    .step    (step)
  );

  // next-state selection
  always_comb begin
    npc_d  = step[1];
    cyc_d  = CYC_W'(1);
    push_d = 1'b0;
    pop_d  = 1'b0;
    ie_d   = 1'b0;
    case (op)
      OP_JMP: begin
        npc_d = rel_tgt;
        cyc_d = CYC_W'(2);
      end
      OP_CALL: begin
        npc_d  = rel_tgt;
        cyc_d  = CYC_W'(3);
        push_d = 1'b1;
      end
      OP_RET, OP_RETI: begin
        npc_d = pop_pc_i;
        cyc_d = CYC_W'(4);
        pop_d = 1'b1;
        ie_d  = (op == OP_RETI);
      end
      OP_BSET, OP_BCLR, OP_SGE, OP_SLT: begin
        if (br_taken) begin
          npc_d = rel_tgt;
          cyc_d = CYC_W'(2);
        end
      end
      OP_SKIP: begin
        if (skip_cond_i) begin
          npc_d = next_two_word_i ? step[3] : step[2];
          cyc_d = next_two_word_i ? CYC_W'(3) : CYC_W'(2);
        end
      end
      default: ;
    endcase
  end

  // registers: result fields load on valid_i, request pulses every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_o     <= '0;
      cycles_o  <= '0;
      push_pc_o <= '0;
    end else if (valid_i) begin
      npc_o     <= npc_d;
      cycles_o  <= cyc_d;
      push_pc_o <= step[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_req_o <= 1'b0;
      pop_req_o  <= 1'b0;
      set_ie_o   <= 1'b0;
    end else begin
      push_req_o <= valid_i & push_d;
      pop_req_o  <= valid_i & pop_d;
      set_ie_o   <= valid_i & ie_d;
    end
  end

  // assertions
  p_push_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_req_o |-> (push_pc_o == $past(pc_i) + PC_W'(1)));

  p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req_o && pop_req_o));

  p_ie_with_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_ie_o |-> pop_req_o);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(npc_o) && $stable(cycles_o) && !push_req_o && !pop_req_o && !set_ie_o));

  p_cyc_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (cycles_o >= 3'd1 && cycles_o <= 3'd4));

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  localparam int PC_W  = 9;
  localparam int OFS_W = 12;

  typedef struct packed {
    logic [3:0]       op;
    logic [PC_W-1:0]  pc;
    logic [OFS_W-1:0] ofs;
    logic [2:0]       sel;
    logic [7:0]       sreg;
    logic             skc;
    logic             two;
    logic [PC_W-1:0]  pop;
    logic [PC_W-1:0]  e_npc;
    logic [2:0]       e_cyc;
    logic             e_push;
    logic             e_pop;
    logic             e_ie;
    logic [7:0]       rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  9'd10,  12'd0,     3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd11,  3'd1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 seq
    '{4'd1,  9'd100, 12'd5,     3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd106, 3'd2, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 jump
    '{4'd1,  9'd100, 12'hF9B,   3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd0,   3'd2, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 back to 0
    '{4'd1,  9'd0,   12'hFFD,   3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd510, 3'd2, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 wrap down
    '{4'd2,  9'd200, 12'd20,    3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd221, 3'd3, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 call
    '{4'd3,  9'd12,  12'd0,     3'd0, 8'h00, 1'b0, 1'b0, 9'd341, 9'd341, 3'd4, 1'b0, 1'b1, 1'b0, 8'd5},  // R5 ret
    '{4'd4,  9'd12,  12'd0,     3'd0, 8'h00, 1'b0, 1'b0, 9'd7,   9'd7,   3'd4, 1'b0, 1'b1, 1'b1, 8'd5},  // R5 reti
    '{4'd5,  9'd50,  12'd10,    3'd1, 8'h02, 1'b0, 1'b0, 9'd0,   9'd61,  3'd2, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 set taken
    '{4'd5,  9'd50,  12'd10,    3'd1, 8'hFD, 1'b0, 1'b0, 9'd0,   9'd51,  3'd1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 set not taken
    '{4'd6,  9'd50,  12'hFF6,   3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd41,  3'd2, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 clear taken
    '{4'd6,  9'd50,  12'hFF6,   3'd7, 8'h80, 1'b0, 1'b0, 9'd0,   9'd51,  3'd1, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 clear not taken
    '{4'd7,  9'd30,  12'd4,     3'd0, 8'h1C, 1'b0, 1'b0, 9'd0,   9'd35,  3'd2, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 ge N=V=1, S=1
    '{4'd7,  9'd30,  12'd4,     3'd0, 8'h04, 1'b0, 1'b0, 9'd0,   9'd31,  3'd1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 ge N only
    '{4'd8,  9'd30,  12'd4,     3'd0, 8'h08, 1'b0, 1'b0, 9'd0,   9'd35,  3'd2, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 lt V only
    '{4'd8,  9'd30,  12'd4,     3'd0, 8'h10, 1'b0, 1'b0, 9'd0,   9'd31,  3'd1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 lt S only
    '{4'd9,  9'd70,  12'd0,     3'd0, 8'h00, 1'b0, 1'b1, 9'd0,   9'd71,  3'd1, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 no skip
    '{4'd9,  9'd70,  12'd0,     3'd0, 8'h00, 1'b1, 1'b0, 9'd0,   9'd72,  3'd2, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 skip one word
    '{4'd9,  9'd70,  12'd0,     3'd0, 8'h00, 1'b1, 1'b1, 9'd0,   9'd73,  3'd3, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 skip two words
    '{4'd9,  9'd510, 12'd0,     3'd0, 8'h00, 1'b1, 1'b1, 9'd0,   9'd1,   3'd3, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 skip wrap
    '{4'd0,  9'd511, 12'd0,     3'd0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd0,   3'd1, 1'b0, 1'b0, 1'b0, 8'd10}, // R10 seq wrap
    '{4'd15, 9'd5,   12'd100,   3'd0, 8'hFF, 1'b1, 1'b1, 9'd99,  9'd6,   3'd1, 1'b0, 1'b0, 1'b0, 8'd2}   // R2 unused code
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             valid_i;
  logic [3:0]       op_i;
  logic [PC_W-1:0]  pc_i;
  logic [OFS_W-1:0] offset_i;
  logic [2:0]       flag_sel_i;
  logic [7:0]       sreg_i;
  logic             skip_cond_i;
  logic             next_two_word_i;
  logic [PC_W-1:0]  pop_pc_i;
  logic [PC_W-1:0]  npc_o;
  logic [2:0]       cycles_o;
  logic             push_req_o;
  logic [PC_W-1:0]  push_pc_o;
  logic             pop_req_o;
  logic             set_ie_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit #(.PC_W(PC_W), .OFS_W(OFS_W)) u_npc_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .pc_i(pc_i),
    .offset_i(offset_i), .flag_sel_i(flag_sel_i), .sreg_i(sreg_i),
    .skip_cond_i(skip_cond_i), .next_two_word_i(next_two_word_i),
    .pop_pc_i(pop_pc_i), .npc_o(npc_o), .cycles_o(cycles_o),
    .push_req_o(push_req_o), .push_pc_o(push_pc_o), .pop_req_o(pop_req_o),
    .set_ie_o(set_ie_o)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_i = v.op; pc_i = v.pc; offset_i = v.ofs; flag_sel_i = v.sel;
    sreg_i = v.sreg; skip_cond_i = v.skc; next_two_word_i = v.two; pop_pc_i = v.pop;
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0;
    op_i = '0; pc_i = '0; offset_i = '0; flag_sel_i = '0; sreg_i = '0;
    skip_cond_i = 1'b0; next_two_word_i = 1'b0; pop_pc_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, with a valid call held on the inputs
    valid_i = 1'b1; drive(VEC[4]);
    @(negedge clk);
    chk("R1", "npc", int'(npc_o), 0);
    chk("R1", "cycles", int'(cycles_o), 0);
    chk("R1", "requests", int'({push_req_o, pop_req_o, set_ie_o}), 0);
    valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].rq);
      drive(VEC[i]);
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      chk(tag, $sformatf("vec%0d npc", i), int'(npc_o), int'(VEC[i].e_npc));
      chk(tag, $sformatf("vec%0d cycles", i), int'(cycles_o), int'(VEC[i].e_cyc));
      chk(tag, $sformatf("vec%0d push", i), int'(push_req_o), int'(VEC[i].e_push));
      chk(tag, $sformatf("vec%0d pop", i), int'(pop_req_o), int'(VEC[i].e_pop));
      chk(tag, $sformatf("vec%0d ie", i), int'(set_ie_o), int'(VEC[i].e_ie));
      if (VEC[i].e_push)
        chk("R4", "push_pc", int'(push_pc_o), (int'(VEC[i].pc) + 1) % 512);
    end

    // R9: idle cycle after a return, changing inputs must not disturb outputs
    drive(VEC[6]); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; drive(VEC[1]);
    @(negedge clk);
    chk("R9", "npc hold", int'(npc_o), 7);
    chk("R9", "cycles hold", int'(cycles_o), 4);
    chk("R9", "pulses low", int'({push_req_o, pop_req_o, set_ie_o}), 0);
    @(negedge clk);
    chk("R9", "npc hold 2", int'(npc_o), 7);

    // R4 push pulse lasts one cycle
    drive(VEC[4]); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R4", "push set", int'(push_req_o), 1);
    @(negedge clk);
    chk("R4", "push one cycle", int'(push_req_o), 0);

    // R5 back-to-back return then call: no overlap of requests
    drive(VEC[5]); valid_i = 1'b1;
    @(negedge clk);
    drive(VEC[4]);
    chk("R5", "pop then", int'({push_req_o, pop_req_o}), 1);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R5", "push after", int'({push_req_o, pop_req_o}), 2);

    // R1 reset mid-run clears registered outputs
    rst_n = 1'b0;
    #1;
    chk("R1", "npc after reset", int'(npc_o), 0);
    chk("R1", "cycles after reset", int'(cycles_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule